// File: doc/BRIEF.md
# Iterative AES Encryption Round Engine

This block encrypts a single 128-bit block with the AES cipher. It works one full round per clock on a 16-byte state held as a 4x4 byte matrix. A start strobe loads the plaintext. In that same cycle the block applies the whitening key. The block then steps through the rounds. It asks for each round key by index on a small lookup port. The key expansion logic sits outside the block and answers that port combinationally, in the same cycle.

Each round applies byte substitution, row rotation, column mixing and key addition, in that order. The final round leaves out the column mixing. A 128-bit key gives 10 rounds and a 256-bit key gives 14. A reserved encoding gives 12 rounds for a 192-bit key. The block needs the same number of cycles for a given key length, whatever the data or key values. A one-cycle done pulse marks the ciphertext as valid. The ciphertext then stays on the output until the next accepted start.

Top module: `aes_round_engine`

## Requirements
- R1: Plaintext, round keys and ciphertext all use one byte layout. Byte k of a 128-bit word sits at bits [127-8k -: 8]. Byte 4c+r belongs to row r and column c of the state.
- R2: The key length input selects the round count. Code 2'b00 gives 10 rounds, 2'b01 gives 12 rounds and 2'b10 or 2'b11 gives 14 rounds. The code is latched when start is accepted.
- R3: While idle, the round-key index output is 0. The key on rk_i in the accepting cycle whitens the plaintext. The index is then 1, 2, and so on up to the round count, one step per cycle. It returns to 0 after the final round.
- R4: Each round applies byte substitution, then rotates row r left by r bytes, then mixes each column with the fixed matrix over GF(2^8) reduced by x^8+x^4+x^3+x+1, then adds the round key. Column mixing is left out in the final round. With a 128-bit key, the expanded schedule gives the standard known-answer ciphertexts.
- R5: With a 192-bit schedule under code 2'b01, or a 256-bit schedule under code 2'b10 or 2'b11, the output is the standard known-answer ciphertext.
- R6: done_o is high for exactly one cycle. It rises on the clock edge that falls a number of cycles after the accepting edge equal to the round count.
- R7: After done, ct_o keeps its value until the next accepted start, whatever the plaintext input does.
- R8: A start strobe while busy is ignored. The running encryption, its plaintext, its round count and its timing are unaffected.
- R9: After reset, done_o is 0, the round-key index is 0 and ct_o is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, accepted only when idle |
| key_len_i | input | 2 | Key length code |
| pt_i | input | 128 | Plaintext block |
| rk_idx_o | output | 4 | Index of the round key wanted this cycle |
| rk_i | input | 128 | Round key for rk_idx_o, same cycle |
| ct_o | output | 128 | Ciphertext, valid from done |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the engine with its default round counts of 10, 12 and 14. This brings all three schedule lengths within reach: the known-answer vectors for 128-, 192- and 256-bit keys, and the index sequence and done timing for each length. The bench expands keys on its own and builds its substitution table by searching for inverses, so a wrong byte order, a missing final-round skip or a wrong row rotation shows up as a ciphertext mismatch. A strobe injected mid-run carries a different plaintext and a different length code, to show that the running encryption is not disturbed.

// File: rtl/aes_pkg.sv
package aes_pkg;
  localparam int unsigned BLK_W = 128;

  // [col][row] byte matrix
  typedef logic [3:0][3:0][7:0] aes_state_t;

  function automatic logic [7:0] xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p;
    logic [7:0] x;
    p = '0;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = xtime(x);
    end
    return p;
  endfunction

  // inverse as x^254 followed by the affine map
  function automatic logic [7:0] sbox_calc(input logic [7:0] x);
    logic [7:0] r;
    logic [7:0] v;
    r = x;
    for (int i = 0; i < 6; i++) r = gf_mul(gf_mul(r, r), x);
    v = gf_mul(r, r);
    return v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]} ^
           {v[3:0], v[7:4]} ^ 8'h63;
  endfunction

  function automatic aes_state_t blk_to_state(input logic [BLK_W-1:0] b);
    aes_state_t s;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        s[c][r] = b[BLK_W-1-8*(4*c+r) -: 8];
    return s;
  endfunction

  function automatic logic [BLK_W-1:0] state_to_blk(input aes_state_t s);
    logic [BLK_W-1:0] b;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        b[BLK_W-1-8*(4*c+r) -: 8] = s[c][r];
    return b;
  endfunction
endpackage

// File: rtl/aes_sbox.sv
module aes_sbox (
  input  logic [7:0] a_i,
  output logic [7:0] y_o
);
  import aes_pkg::*;
  assign y_o = sbox_calc(a_i);
endmodule

// File: rtl/aes_sub_shift.sv
module aes_sub_shift
  import aes_pkg::*;
(
  input  aes_state_t st_i,
  output aes_state_t st_o
);
  // out[c][r] = S(in[(c+r)%4][r])
  for (genvar c = 0; c < 4; c++) begin : g_col
    for (genvar r = 0; r < 4; r++) begin : g_row
      localparam int SRC_C = (c + r) % 4;
      aes_sbox u_sbox (
        .a_i (st_i[SRC_C][r]),
        .y_o (st_o[c][r])
      );
    end
  end
endmodule

// File: rtl/aes_mix_cols.sv
module aes_mix_cols
  import aes_pkg::*;
(
  input  aes_state_t st_i,
  output aes_state_t st_o
);
  for (genvar c = 0; c < 4; c++) begin : g_col
    logic [7:0] a0, a1, a2, a3;
    assign a0 = st_i[c][0];
    assign a1 = st_i[c][1];
    assign a2 = st_i[c][2];
    assign a3 = st_i[c][3];
    assign st_o[c][0] = xtime(a0) ^ (xtime(a1) ^ a1) ^ a2 ^ a3;
    assign st_o[c][1] = a0 ^ xtime(a1) ^ (xtime(a2) ^ a2) ^ a3;
    assign st_o[c][2] = a0 ^ a1 ^ xtime(a2) ^ (xtime(a3) ^ a3);
    assign st_o[c][3] = (xtime(a0) ^ a0) ^ a1 ^ a2 ^ xtime(a3);
  end
endmodule

// File: rtl/aes_ctrl.sv
module aes_ctrl #(
  parameter int unsigned NR_128 = 10,
  parameter int unsigned NR_192 = 12,
  parameter int unsigned NR_256 = 14,
  parameter int unsigned IDX_W  = $clog2(NR_256 + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       key_len_i,
  output logic             accept_o,
  output logic             busy_o,
  output logic             last_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             done_o
);
  logic             busy_q, done_q;
  logic [IDX_W-1:0] idx_q, nr_q, nr_sel;

  always_comb begin
    unique case (key_len_i)
      2'b00:   nr_sel = IDX_W'(NR_128);
      2'b01:   nr_sel = IDX_W'(NR_192);
      default: nr_sel = IDX_W'(NR_256);
    endcase
  end

  assign accept_o = start_i & ~busy_q;
  assign last_o   = busy_q & (idx_q == nr_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      nr_q   <= IDX_W'(NR_128);
      done_q <= 1'b0;
    end else begin
      done_q <= last_o;
      if (accept_o) begin
        busy_q <= 1'b1;
        idx_q  <= IDX_W'(1);
        nr_q   <= nr_sel;
      end else if (busy_q) begin
        if (last_o) begin
          busy_q <= 1'b0;
          idx_q  <= '0;
        end else begin
          idx_q <= idx_q + IDX_W'(1);
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign idx_o  = idx_q;
  assign done_o = done_q;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R6
  AST_DONE_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> done_q && !busy_q); // R6
  AST_IDX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !last_o) |=> busy_q && idx_q == $past(idx_q) + IDX_W'(1)); // R3
  AST_IDLE_IDX_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> idx_q == '0); // R3
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i) |=> $stable(nr_q)); // R8
  AST_ROUND_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (nr_q == IDX_W'(NR_128) || nr_q == IDX_W'(NR_192) ||
                nr_q == IDX_W'(NR_256)) && idx_q <= nr_q); // R2
endmodule

// File: rtl/aes_round_engine.sv
module aes_round_engine #(
  parameter int unsigned NR_128 = 10,
  parameter int unsigned NR_192 = 12,
  parameter int unsigned NR_256 = 14,
  localparam int unsigned IDX_W = $clog2(NR_256 + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       key_len_i,
  input  logic [127:0]     pt_i,
  output logic [IDX_W-1:0] rk_idx_o,
  input  logic [127:0]     rk_i,
  output logic [127:0]     ct_o,
  output logic             done_o
);
  import aes_pkg::*;

  logic       accept, busy, last;
  aes_state_t st_q, st_d, st_sr, st_mc, st_pre, rk_st;

  aes_ctrl #(
    .NR_128 (NR_128),
    .NR_192 (NR_192),
    .NR_256 (NR_256),
    .IDX_W  (IDX_W)
  ) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .key_len_i (key_len_i),
    .accept_o  (accept),
    .busy_o    (busy),
    .last_o    (last),
    .idx_o     (rk_idx_o),
    .done_o    (done_o)
  );

  aes_sub_shift u_sub_shift (
    .st_i (st_q),
    .st_o (st_sr)
  );

  aes_mix_cols u_mix_cols (
    .st_i (st_sr),
    .st_o (st_mc)
  );

  assign rk_st = blk_to_state(rk_i);

  always_comb begin
    if (accept)    st_pre = blk_to_state(pt_i);
    else if (last) st_pre = st_sr;
    else           st_pre = st_mc;
    st_d = st_pre ^ rk_st;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                st_q <= '0;
    else if (accept || busy)    st_q <= st_d;
  end

  assign ct_o = state_to_blk(st_q);

  AST_CT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && !start_i) |=> $stable(ct_o)); // R7
  AST_WHITEN_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> ct_o == $past(pt_i ^ rk_i)); // R3
endmodule

// File: tb/aes_round_engine_tb_top.sv
module aes_round_engine_tb_top;
  logic         clk;
  logic         rst_ni;
  logic         start_i;
  logic [1:0]   key_len_i;
  logic [127:0] pt_i;
  logic [3:0]   rk_idx_o;
  logic [127:0] rk_i;
  logic [127:0] ct_o;
  logic         done_o;

  int checks = 0;
  int errors = 0;

  logic [7:0]   sb [256];
  logic [31:0]  w  [60];
  logic [127:0] rk_tab [16];

  aes_round_engine dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .key_len_i (key_len_i),
    .pt_i      (pt_i),
    .rk_idx_o  (rk_idx_o),
    .rk_i      (rk_i),
    .ct_o      (ct_o),
    .done_o    (done_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always_comb rk_i = rk_tab[rk_idx_o];

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired: act=running exp=finished");
    summary();
  end

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] m8(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = '0;
    logic [7:0] x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p ^= x;
      x = {x[6:0], 1'b0} ^ (x[7] ? 8'h1b : 8'h00);
    end
    return p;
  endfunction

  // substitution table by inverse search, independent of the RTL method
  task automatic build_sbox();
    for (int x = 0; x < 256; x++) begin
      logic [7:0] inv = '0;
      logic [7:0] s;
      for (int y = 1; y < 256; y++)
        if (m8(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
      s = 8'h63;
      for (int i = 0; i < 8; i++)
        s[i] = s[i] ^ inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8];
      sb[x] = s;
    end
  endtask

  function automatic logic [31:0] subw(input logic [31:0] v);
    return {sb[v[31:24]], sb[v[23:16]], sb[v[15:8]], sb[v[7:0]]};
  endfunction

  task automatic expand(input int nk, input logic [255:0] key);
    logic [7:0] rc = 8'h01;
    int nr = nk + 6;
    for (int i = 0; i < nk; i++) w[i] = key[255-32*i -: 32];
    for (int i = nk; i < 4*(nr+1); i++) begin
      logic [31:0] t = w[i-1];
      if (i % nk == 0) begin
        t = subw({t[23:0], t[31:24]}) ^ {rc, 24'h0};
        rc = m8(rc, 8'h02);
      end else if (nk > 6 && i % nk == 4) begin
        t = subw(t);
      end
      w[i] = w[i-nk] ^ t;
    end
    for (int j = 0; j < 16; j++)
      rk_tab[j] = (j <= nr) ? {w[4*j], w[4*j+1], w[4*j+2], w[4*j+3]} : '0;
  endtask

  // one encryption; poke injects a start strobe while busy (R8)
  task automatic run_blk(input logic [1:0] kl, input int nk, input logic [255:0] key,
                         input logic [127:0] pt, input logic [127:0] exp,
                         input string tag, input bit poke);
    int nr = nk + 6;
    expand(nk, key);
    @(negedge clk);
    chk(rk_idx_o == 4'd0, "R3 idle index", 128'(rk_idx_o), 128'd0);
    start_i = 1'b1; key_len_i = kl; pt_i = pt;
    @(negedge clk);
    start_i = 1'b0;
    chk(rk_idx_o == 4'd1, "R3 first round index", 128'(rk_idx_o), 128'd1);
    for (int k = 1; k <= nr; k++) begin
      if (poke && k == 3) begin
        start_i = 1'b1; pt_i = ~pt; key_len_i = 2'b00;
      end
      @(negedge clk);
      start_i = 1'b0;
      if (k < nr) begin
        chk(done_o == 1'b0, "R6 no early done", 128'(done_o), 128'd0);
        chk(rk_idx_o == 4'(k+1), "R3 index step", 128'(rk_idx_o), 128'(k+1));
      end else begin
        chk(done_o == 1'b1, "R6 done at round count", 128'(done_o), 128'd1);
        chk(ct_o == exp, tag, ct_o, exp);
        chk(rk_idx_o == 4'd0, "R3 index back to 0", 128'(rk_idx_o), 128'd0);
      end
    end
    @(negedge clk);
    chk(done_o == 1'b0, "R6 done one cycle", 128'(done_o), 128'd0);
    chk(ct_o == exp, "R7 ct held after done", ct_o, exp);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0; start_i = 1'b0; key_len_i = 2'b00; pt_i = '0;
    repeat (3) @(negedge clk);
    chk(done_o == 1'b0, "R9 reset done", 128'(done_o), 128'd0);
    chk(rk_idx_o == 4'd0, "R9 reset index", 128'(rk_idx_o), 128'd0);
    chk(ct_o == '0, "R9 reset ct", ct_o, 128'd0);
    rst_ni = 1'b1;
  endtask

  task automatic t_kat_128();
    run_blk(2'b00, 4, {128'h000102030405060708090a0b0c0d0e0f, 128'h0},
            128'h00112233445566778899aabbccddeeff,
            128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R4 R1 128-bit vector A", 1'b0);
    run_blk(2'b00, 4, {128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h0},
            128'h3243f6a8885a308d313198a2e0370734,
            128'h3925841d02dc09fbdc118597196a0b32, "R4 R1 128-bit vector B", 1'b0);
  endtask

  task automatic t_kat_long();
    run_blk(2'b01, 6, {192'h000102030405060708090a0b0c0d0e0f1011121314151617, 64'h0},
            128'h00112233445566778899aabbccddeeff,
            128'hdda97ca4864cdfe06eaf70a0ec0d7191, "R5 R2 192-bit vector", 1'b0);
    run_blk(2'b10, 8, 256'h000102030405060708090a0b0c0d0e0f101112131415161718191a1b1c1d1e1f,
            128'h00112233445566778899aabbccddeeff,
            128'h8ea2b7ca516745bfeafc49904b496089, "R5 256-bit vector code 10", 1'b0);
    run_blk(2'b11, 8, 256'h000102030405060708090a0b0c0d0e0f101112131415161718191a1b1c1d1e1f,
            128'h00112233445566778899aabbccddeeff,
            128'h8ea2b7ca516745bfeafc49904b496089, "R2 256-bit vector code 11", 1'b0);
  endtask

  task automatic t_start_busy();
    run_blk(2'b10, 8, 256'h000102030405060708090a0b0c0d0e0f101112131415161718191a1b1c1d1e1f,
            128'h00112233445566778899aabbccddeeff,
            128'h8ea2b7ca516745bfeafc49904b496089, "R8 start while busy ignored", 1'b1);
  endtask

  task automatic t_hold();
    logic [127:0] held = ct_o;
    for (int i = 0; i < 5; i++) begin
      pt_i = {4{32'(i * 32'h9e3779b9)}};
      key_len_i = 2'(i);
      @(negedge clk);
      chk(ct_o == held, "R7 ct stable while idle", ct_o, held);
      chk(done_o == 1'b0, "R6 no spurious done", 128'(done_o), 128'd0);
    end
  endtask

  initial begin
    for (int j = 0; j < 16; j++) rk_tab[j] = '0;
    build_sbox();
    t_reset();
    t_kat_128();
    t_hold();
    t_kat_long();
    t_start_busy();
    t_hold();
    summary();
  end
endmodule